// File: doc/BRIEF.md
# Two-Count PWM Generator

This block is a single-channel pulse-width modulator placed on a simple synchronous 32-bit register port. Software does not program a period and a duty value. It programs the number of clocks the pin stays high and the number of clocks it stays low, as two separate unsigned counts. The period is the sum of the two counts. Software converts times into clock counts before it writes them.

Count writes go to pending registers. They reach the active (shadow) counts only when software sets the update bit in the control register. The transfer happens at the end of the current period, or at once when the counter is stopped or idle. The update bit then clears itself. The pin is driven only while both the counter enable and the output enable are set.

A typical sequence writes the high count, then the low count, then the control register. To start the channel, that control write sets the enable, output-enable and update bits together. Writing zero to the control register turns the channel off.

Top module: `pwm_onoff`

## Requirements
- R1: After reset, `pwm_out` is low and the control, high-count and low-count registers all read as zero.
- R2: The high count at offset 0x1C and the low count at offset 0x18 read back the full 32-bit value last written. The control register at offset 0x00 reads the counter enable in bit 0 and the output enable in bit 14, and bit 5 reads 1 while an update is pending. All other control bits read 0.
- R3: An offset other than 0x00, 0x18 or 0x1C reads as zero, and a write to such an offset changes no register.
- R4: A write to a count register does not alter the waveform until an update is requested.
- R5: When a control write sets the enable, output-enable and update bits, `pwm_out` is low after the next clock edge. From the following edge on, it is high for the high count of clocks and then low for the low count of clocks, repeating.
- R6: An update requested while the counter runs takes effect at the first period end after the request. The waveform of the current period is not cut short, and the next period starts at its high phase with the new counts.
- R7: With the counter enabled and the output enable clear, `pwm_out` stays low.
- R8: A high count of zero gives a constant low output. A low count of zero with a nonzero high count gives a constant high output. Both counts zero gives a low output with the counter idle, and a pending update is still taken.
- R9: After a control write clears the counter enable, `pwm_out` keeps its value for one more clock and then is low. A later enable restarts the period at the start of its high phase.
- R10: An update requested while the counter is stopped copies the pending counts on the next clock edge. The update bit then reads 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in cycles of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data, all bits written together |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output pin |

## Verification
The properties assume the register port changes only between clock edges and that each write is a single-cycle strobe with a stable address. The stimulus drives every input on the falling edge and holds each write for exactly one cycle. The timing checks assume the default registered output stage. The scoreboard assumes no write lands between a queued window and its expected effect except the writes the driver places at counted falling edges. For that reason every mid-stream write is issued after a fixed number of falling edges following the enable.

// File: rtl/pwm_onoff_pkg.sv
package pwm_onoff_pkg;

   // Control bits held by the register file
   typedef struct packed {
      logic en;    // counter enable
      logic oe;    // output enable
      logic upd;   // pending shadow transfer request
   } ctrl_t;

   // Register decode result
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_LOW  = 2'd2,
      SEL_HIGH = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/pwm_onoff_regs.sv
module pwm_onoff_regs
   import pwm_onoff_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFS = 'h00,
   parameter int OFF_OFS  = 'h18,
   parameter int ON_OFS   = 'h1C,
   parameter int EN_BIT   = 0,
   parameter int UPD_BIT  = 5,
   parameter int OE_BIT   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              load_ack,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] pend_on,
   output logic [DATA_W-1:0] pend_off
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFF_OFS);
   localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(ON_OFS);

   reg_sel_e sel;

   always_comb begin
      if (bus_addr == A_CTRL)      sel = SEL_CTRL;
      else if (bus_addr == A_LOW)  sel = SEL_LOW;
      else if (bus_addr == A_HIGH) sel = SEL_HIGH;
      else                         sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         pend_on  <= '0;
         pend_off <= '0;
      end else begin
         if (bus_we && sel == SEL_HIGH) pend_on  <= bus_wdata;
         if (bus_we && sel == SEL_LOW)  pend_off <= bus_wdata;
         if (bus_we && sel == SEL_CTRL) begin
            ctrl_q.en  <= bus_wdata[EN_BIT];
            ctrl_q.oe  <= bus_wdata[OE_BIT];
            ctrl_q.upd <= bus_wdata[UPD_BIT];
         end else if (load_ack) begin
            ctrl_q.upd <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CTRL: begin
            bus_rdata[EN_BIT]  = ctrl_q.en;
            bus_rdata[OE_BIT]  = ctrl_q.oe;
            bus_rdata[UPD_BIT] = ctrl_q.upd;
         end
         SEL_LOW:  bus_rdata = pend_off;
         SEL_HIGH: bus_rdata = pend_on;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pwm_onoff_shadow.sv
module pwm_onoff_shadow #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_ack,
   input  logic [CNT_W-1:0] pend_on,
   input  logic [CNT_W-1:0] pend_off,
   output logic [CNT_W-1:0] act_on,
   output logic [CNT_W-1:0] act_off
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_on  <= '0;
         act_off <= '0;
      end else if (load_ack) begin
         act_on  <= pend_on;
         act_off <= pend_off;
      end
   end

endmodule

// File: rtl/pwm_onoff_counter.sv
module pwm_onoff_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             upd_req,
   input  logic [CNT_W-1:0] act_on,
   input  logic [CNT_W-1:0] act_off,
   output logic             load_ack,
   output logic             started,
   output logic             boundary,
   output logic [CNT_W:0]   period,
   output logic [CNT_W:0]   cnt,
   output logic             on_phase
);

   // The period needs one extra bit: both counts may be all ones.
   localparam int PER_W = CNT_W + 1;

   assign period   = {1'b0, act_on} + {1'b0, act_off};
   // A zero period is an idle counter that is always at a boundary.
   assign boundary = (period == '0) || (started && (cnt == period - PER_W'(1)));
   assign load_ack = upd_req && (!en || !started || boundary);
   assign on_phase = started && (cnt < {1'b0, act_on});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         cnt     <= '0;
      end else if (!en) begin
         started <= 1'b0;
         cnt     <= '0;
      end else if (!started) begin
         started <= 1'b1;
         cnt     <= '0;
      end else if (boundary) begin
         cnt     <= '0;
      end else begin
         cnt     <= cnt + PER_W'(1);
      end
   end

endmodule

// File: rtl/pwm_onoff_outstage.sv
module pwm_onoff_outstage #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic oe,
   input  logic on_phase,
   output logic pwm_out
);

   logic drive;
   assign drive = en && oe && on_phase;

   if (REG_OUT) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_out <= 1'b0;
         else        pwm_out <= drive;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pwm_out = drive;
   end

endmodule

// File: rtl/pwm_onoff.sv
module pwm_onoff
   import pwm_onoff_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFS = 'h00,
   parameter int OFF_OFS  = 'h18,
   parameter int ON_OFS   = 'h1C,
   parameter int EN_BIT   = 0,
   parameter int UPD_BIT  = 5,
   parameter int OE_BIT   = 14,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);

   localparam int CNT_W = DATA_W;

   // Elaboration-time parameter checks
   if (EN_BIT >= DATA_W || UPD_BIT >= DATA_W || OE_BIT >= DATA_W) begin : g_bad_bit
      $error("control bit position outside the data width");
   end
   if (EN_BIT == UPD_BIT || EN_BIT == OE_BIT || UPD_BIT == OE_BIT) begin : g_dup_bit
      $error("control bit positions must differ");
   end
   if (CTRL_OFS == OFF_OFS || CTRL_OFS == ON_OFS || OFF_OFS == ON_OFS) begin : g_dup_ofs
      $error("register offsets must differ");
   end
   if ((CTRL_OFS >> ADDR_W) != 0 || (OFF_OFS >> ADDR_W) != 0 || (ON_OFS >> ADDR_W) != 0) begin : g_big_ofs
      $error("register offset does not fit the address width");
   end
   if (ADDR_W < 2 || DATA_W < 2) begin : g_small
      $error("address and data widths must be at least 2");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] pend_on;
   logic [CNT_W-1:0] pend_off;
   logic [CNT_W-1:0] act_on;
   logic [CNT_W-1:0] act_off;
   logic             load_ack;
   logic             started;
   logic             boundary;
   logic [CNT_W:0]   period;
   logic [CNT_W:0]   cnt;
   logic             on_phase;

   pwm_onoff_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CTRL_OFS(CTRL_OFS), .OFF_OFS(OFF_OFS), .ON_OFS(ON_OFS),
      .EN_BIT(EN_BIT), .UPD_BIT(UPD_BIT), .OE_BIT(OE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .load_ack(load_ack),
      .ctrl_q(ctrl_q), .pend_on(pend_on), .pend_off(pend_off)
   );

   pwm_onoff_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load_ack(load_ack),
      .pend_on(pend_on), .pend_off(pend_off),
      .act_on(act_on), .act_off(act_off)
   );

   pwm_onoff_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.en), .upd_req(ctrl_q.upd),
      .act_on(act_on), .act_off(act_off),
      .load_ack(load_ack), .started(started), .boundary(boundary),
      .period(period), .cnt(cnt), .on_phase(on_phase)
   );

   pwm_onoff_outstage #(.REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.en), .oe(ctrl_q.oe), .on_phase(on_phase),
      .pwm_out(pwm_out)
   );

endmodule

// File: rtl/pwm_onoff_chk.sv
module pwm_onoff_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFS = 'h00,
   parameter int OFF_OFS  = 'h18,
   parameter int ON_OFS   = 'h1C,
   parameter bit REG_OUT  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              pwm_out,
   input logic              ctrl_en,
   input logic              ctrl_oe,
   input logic              upd_pend,
   input logic [DATA_W-1:0] pend_on,
   input logic [DATA_W-1:0] pend_off,
   input logic [DATA_W-1:0] act_on,
   input logic [DATA_W-1:0] act_off,
   input logic              started,
   input logic              boundary,
   input logic [DATA_W:0]   period,
   input logic [DATA_W:0]   cnt
);

   logic wr_ctrl, wr_high, wr_unmapped;
   assign wr_ctrl     = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
   assign wr_high     = bus_we && (bus_addr == ADDR_W'(ON_OFS));
   assign wr_unmapped = bus_we && (bus_addr != ADDR_W'(CTRL_OFS))
                        && (bus_addr != ADDR_W'(OFF_OFS))
                        && (bus_addr != ADDR_W'(ON_OFS));

   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_high |=> (pend_on == $past(bus_wdata)));

   p_unmapped_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_unmapped && !upd_pend) |=> ($stable(pend_on) && $stable(pend_off)
                                      && $stable(ctrl_en) && $stable(ctrl_oe)));

   p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (started && period != '0) |-> (cnt < period));

   p_shadow_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && started && !boundary) |=> ($stable(act_on) && $stable(act_off)));

   p_stop_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (cnt == '0 && !started));

   p_stopped_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_pend && !ctrl_en && !wr_ctrl) |=> !upd_pend);

   if (REG_OUT) begin : g_pin
      p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl_en || !ctrl_oe) |=> !pwm_out);

      p_zero_high_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (act_on == '0) |=> !pwm_out);
   end

endmodule

bind pwm_onoff pwm_onoff_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .CTRL_OFS(CTRL_OFS), .OFF_OFS(OFF_OFS), .ON_OFS(ON_OFS),
   .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
   .pwm_out(pwm_out),
   .ctrl_en(ctrl_q.en), .ctrl_oe(ctrl_q.oe), .upd_pend(ctrl_q.upd),
   .pend_on(pend_on), .pend_off(pend_off),
   .act_on(act_on), .act_off(act_off),
   .started(started), .boundary(boundary),
   .period(period), .cnt(cnt)
);

// File: tb/pwm_onoff_tb.sv
`timescale 1ns/1ps
module pwm_onoff_tb;

   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_LOW  = 8'h18;
   localparam logic [7:0] A_HIGH = 8'h1C;
   localparam logic [31:0] C_EN  = 32'h0000_0001;
   localparam logic [31:0] C_UPD = 32'h0000_0020;
   localparam logic [31:0] C_OE  = 32'h0000_4000;
   localparam logic [31:0] C_RUN = C_EN | C_OE | C_UPD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;

   int n_chk = 0;
   int n_fail = 0;

   logic  q_val[$];
   string q_tag[$];

   always #5 clk = ~clk;

   pwm_onoff u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Driver side of the scoreboard: queue the expected pin level per clock
   task automatic push_one(input logic v, input string tag);
      q_val.push_back(v);
      q_tag.push_back(tag);
   endtask

   task automatic push_wave(input int hi, input int lo, input int reps, input string tag);
      for (int r = 0; r < reps; r++) begin
         for (int i = 0; i < hi; i++) push_one(1'b1, tag);
         for (int i = 0; i < lo; i++) push_one(1'b0, tag);
      end
   endtask

   task automatic push_level(input logic v, input int n, input string tag);
      for (int i = 0; i < n; i++) push_one(v, tag);
   endtask

   // Called on a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic drain();
      while (q_val.size() > 0) @(negedge clk);
   endtask

   // Monitor side: compare the pin after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_val.size() > 0) begin
            logic  v;
            string t;
            v = q_val.pop_front();
            t = q_tag.pop_front();
            chk(pwm_out === v, t, {31'b0, pwm_out}, {31'b0, v});
         end
      end
   end

   initial begin
      #1_500_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(pwm_out === 1'b0, "R1 pin", {31'b0, pwm_out}, 32'h0);
      rd(A_CTRL, 32'h0, "R1 ctrl");
      rd(A_HIGH, 32'h0, "R1 high");
      rd(A_LOW,  32'h0, "R1 low");

      // R2 and R3: readback and unmapped offsets
      @(negedge clk);
      wr(A_HIGH, 32'hDEAD_BEEF);
      wr(A_LOW,  32'h1234_5678);
      rd(A_HIGH, 32'hDEAD_BEEF, "R2 high");
      rd(A_LOW,  32'h1234_5678, "R2 low");
      @(negedge clk);
      wr(A_CTRL, C_OE | 32'hFFFF_BFDE);
      rd(A_CTRL, C_OE, "R2 ctrl other bits");
      @(negedge clk);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h20, 32'h0000_0001);
      rd(8'h04, 32'h0, "R3 read 04");
      rd(8'h20, 32'h0, "R3 read 20");
      rd(A_HIGH, 32'hDEAD_BEEF, "R3 high kept");
      rd(A_LOW,  32'h1234_5678, "R3 low kept");
      rd(A_CTRL, C_OE, "R3 ctrl kept");
      chk(pwm_out === 1'b0, "R7 oe without enable", {31'b0, pwm_out}, 32'h0);
      @(negedge clk);
      wr(A_CTRL, 32'h0);

      // R5, R4, R6: start 3/5, rewrite counts, update mid period
      wr(A_HIGH, 32'd3);
      wr(A_LOW,  32'd5);
      wr(A_CTRL, C_RUN);            // edge k
      push_one(1'b0, "R5 first edge");
      push_wave(3, 5, 1, "R5");
      push_wave(3, 5, 2, "R4");
      push_wave(6, 2, 3, "R6");
      wr(A_HIGH, 32'd6);            // edge k+1
      wr(A_LOW,  32'd2);            // edge k+2
      repeat (17) @(negedge clk);
      wr(A_CTRL, C_RUN);            // edge k+20, takes effect at edge k+25
      drain();
      rd(A_CTRL, C_EN | C_OE, "R6 update cleared");

      // R7: enabled, output disabled
      @(negedge clk);
      wr(A_CTRL, C_EN);
      push_level(1'b0, 16, "R7");
      drain();

      // R9: stop
      wr(A_CTRL, 32'h0);
      push_level(1'b0, 4, "R9");
      drain();

      // R8: zero low count holds the pin high
      wr(A_HIGH, 32'd2);
      wr(A_LOW,  32'd0);
      wr(A_CTRL, C_RUN);
      push_one(1'b0, "R8 first edge");
      push_level(1'b1, 20, "R8 constant high");
      drain();
      chk(pwm_out === 1'b1, "R8 still high", {31'b0, pwm_out}, 32'h1);

      // R9: pin keeps its level one clock, then low
      wr(A_CTRL, 32'h0);
      chk(pwm_out === 1'b1, "R9 one clock", {31'b0, pwm_out}, 32'h1);
      push_level(1'b0, 3, "R9 low");
      drain();
      wr(A_HIGH, 32'd4);            // no update: shadow keeps 2/0
      wr(A_LOW,  32'd4);
      wr(A_CTRL, C_EN | C_OE);
      push_one(1'b0, "R9 restart");
      push_level(1'b1, 6, "R9 restart high");
      drain();
      wr(A_CTRL, 32'h0);

      // R10: update while stopped
      @(negedge clk);
      wr(A_CTRL, C_UPD);
      rd(A_CTRL, C_UPD, "R10 pending");
      @(negedge clk);
      rd(A_CTRL, 32'h0, "R10 self clear");
      @(negedge clk);
      wr(A_CTRL, C_EN | C_OE);
      push_one(1'b0, "R10 first edge");
      push_wave(4, 4, 2, "R10 new counts");
      drain();
      wr(A_CTRL, 32'h0);

      // R8: zero high count, then both zero
      wr(A_HIGH, 32'd0);
      wr(A_LOW,  32'd4);
      wr(A_CTRL, C_RUN);
      push_level(1'b0, 16, "R8 constant low");
      drain();
      rd(A_CTRL, C_EN | C_OE, "R8 update taken");
      @(negedge clk);
      wr(A_LOW, 32'd0);
      wr(A_CTRL, C_RUN);
      push_level(1'b0, 10, "R8 idle");
      drain();
      rd(A_CTRL, C_EN | C_OE, "R8 idle update taken");
      @(negedge clk);
      wr(A_CTRL, 32'h0);
      repeat (2) @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule